// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day in half-second resolution. A chain of three wrapping counters (half-seconds within a minute, minutes within an hour, hours within a day) steps forward each time an internal prescaler sees the configured number of tick enable pulses. With the default settings there is one pulse every 0.5 s, so the chain advances on every tick. Software sets and reads the counters through a simple register write and read port. Reading the half-second field also latches the minute and hour fields, so a multi-field read returns one coherent time.

Two one-cycle interrupt pulses come out. The interval interrupt is raised on a selectable rollover boundary: every advance, every full second, every minute, every hour or every day. The alarm interrupt is raised when an advance lands the chain exactly on the programmed alarm time. Software writes to the time fields take effect at once. They restart the prescaler phase, and they never produce an interval or alarm pulse.

Top module: `tod_alarm_counter`

## Requirements
- R1: The half-second field steps by one on each advance, from 0 up to HS_PER_MIN-1, and then returns to 0. An advance occurs when the prescaler reaches PRE_DIV tick pulses. Without an advance or a write, the field holds its value.
- R2: The minute field steps when the half-second field wraps, and returns to 0 after MIN_PER_HOUR-1. The hour field steps when both lower fields wrap, and returns to 0 after HR_PER_DAY-1. Without an advance or a write, both fields hold.
- R3: The prescaler counts tick pulses and produces one advance per PRE_DIV pulses. A write to any time field clears the prescaler count, so the next advance needs a full PRE_DIV further pulses.
- R4: Writes load fields by address: address 0 for half-seconds, 1 for minutes, 2 for hours, 3, 4 and 5 for the alarm half-second, minute and hour fields. Any value at or above that field's modulus loads 0.
- R5: Control address 6 holds the interval select in bits [2:0]. The codes are: 0 off, 1 every advance, 2 when the new half-second value is even, 3 on a minute rollover, 4 on an hour rollover, 5 on a day rollover, 6 and 7 off. `irq_interval_o` is high for exactly the one cycle after the selected advance.
- R6: A time write in the same cycle as a terminal tick blocks that advance. No interval pulse follows a time write.
- R7: Control bit 3 enables the alarm. With it set, `irq_alarm_o` pulses for one cycle after an advance whose resulting time equals all three alarm fields. Writing the time directly to the alarm value gives no pulse, and with the enable clear no pulse is given.
- R8: After an alarm pulse, no further alarm pulse occurs until the chain returns to the alarm time one full day later.
- R9: A read of address 0 with `rd_en_i` high latches the current minute and hour. Reads of addresses 1 and 2 return those latched values, not the live ones.
- R10: After reset, all counters, alarm fields, control bits and latched values are 0 and both interrupts are low. Reads of addresses 3 to 6 return the stored alarm and control values, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick enable, one pulse per prescaler step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_en_i | input | 1 | Read strobe; at address 0 it latches minute and hour |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DW | Read data (combinational) |
| irq_interval_o | output | 1 | Interval interrupt pulse |
| irq_alarm_o | output | 1 | Alarm match interrupt pulse |

## Verification
The bench builds the block with HS_PER_MIN=4, MIN_PER_HOUR=3, HR_PER_DAY=2 and PRE_DIV=2. A whole day is therefore 24 advances, or 48 ticks. With these values every rollover is reached in a short run: half-second to minute, minute to hour, and the day wrap. Every interval code can be compared against a reference model over a full day, and the alarm can be seen to return exactly one day after it first fires. A divider of two makes the prescaler phase visible at the ports, so both the restart on a time write and the blocked advance can be checked.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [2:0] ADR_HS   = 3'd0;
  localparam logic [2:0] ADR_MN   = 3'd1;
  localparam logic [2:0] ADR_HR   = 3'd2;
  localparam logic [2:0] ADR_A_HS = 3'd3;
  localparam logic [2:0] ADR_A_MN = 3'd4;
  localparam logic [2:0] ADR_A_HR = 3'd5;
  localparam logic [2:0] ADR_CTRL = 3'd6;

  typedef enum logic [2:0] {
    IV_OFF  = 3'd0,
    IV_HALF = 3'd1,
    IV_SEC  = 3'd2,
    IV_MIN  = 3'd3,
    IV_HOUR = 3'd4,
    IV_DAY  = 3'd5
  } iv_sel_e;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    last  = (cnt_q == PW'(DIV - 1));
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = last ? '0 : cnt_q + 1'b1;
    adv_o = tick_i & last & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tod_digit.sv
module tod_digit #(
  parameter int MOD = 60,
  parameter int W   = 6,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  nxt_o,
  output logic          last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    last_o = (cnt_q == W'(MOD - 1));
    cnt_d  = cnt_q;
    if (ld_i)       cnt_d = (ld_val_i < DW'(MOD)) ? ld_val_i[W-1:0] : '0;
    else if (inc_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = cnt_d;
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DW = 8,
  parameter int HS_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HR_PER_DAY = 24,
  parameter int HW = 7,
  parameter int MW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [2:0]    rd_addr_i,
  input  logic [HW-1:0] hs_i,
  input  logic [MW-1:0] mn_i,
  input  logic [RW-1:0] hr_i,
  output logic [HW-1:0] a_hs_o,
  output logic [MW-1:0] a_mn_o,
  output logic [RW-1:0] a_hr_o,
  output logic [2:0]    sel_o,
  output logic          alarm_en_o,
  output logic [DW-1:0] rd_data_o
);
  logic [HW-1:0] a_hs_q, a_hs_d;
  logic [MW-1:0] a_mn_q, a_mn_d;
  logic [RW-1:0] a_hr_q, a_hr_d;
  logic [3:0]    ctrl_q, ctrl_d;
  logic [MW-1:0] snap_mn_q, snap_mn_d;
  logic [RW-1:0] snap_hr_q, snap_hr_d;

  always_comb begin
    a_hs_d    = a_hs_q;
    a_mn_d    = a_mn_q;
    a_hr_d    = a_hr_q;
    ctrl_d    = ctrl_q;
    snap_mn_d = snap_mn_q;
    snap_hr_d = snap_hr_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADR_A_HS: a_hs_d = (wr_data_i < DW'(HS_PER_MIN))   ? wr_data_i[HW-1:0] : '0;
        ADR_A_MN: a_mn_d = (wr_data_i < DW'(MIN_PER_HOUR)) ? wr_data_i[MW-1:0] : '0;
        ADR_A_HR: a_hr_d = (wr_data_i < DW'(HR_PER_DAY))   ? wr_data_i[RW-1:0] : '0;
        ADR_CTRL: ctrl_d = wr_data_i[3:0];
        default:  ;
      endcase
    end
    if (rd_en_i && rd_addr_i == ADR_HS) begin
      snap_mn_d = mn_i;
      snap_hr_d = hr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hs_q    <= '0;
      a_mn_q    <= '0;
      a_hr_q    <= '0;
      ctrl_q    <= '0;
      snap_mn_q <= '0;
      snap_hr_q <= '0;
    end else begin
      a_hs_q    <= a_hs_d;
      a_mn_q    <= a_mn_d;
      a_hr_q    <= a_hr_d;
      ctrl_q    <= ctrl_d;
      snap_mn_q <= snap_mn_d;
      snap_hr_q <= snap_hr_d;
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADR_HS:   rd_data_o = DW'(hs_i);
      ADR_MN:   rd_data_o = DW'(snap_mn_q);
      ADR_HR:   rd_data_o = DW'(snap_hr_q);
      ADR_A_HS: rd_data_o = DW'(a_hs_q);
      ADR_A_MN: rd_data_o = DW'(a_mn_q);
      ADR_A_HR: rd_data_o = DW'(a_hr_q);
      ADR_CTRL: rd_data_o = DW'(ctrl_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign a_hs_o     = a_hs_q;
  assign a_mn_o     = a_mn_q;
  assign a_hr_o     = a_hr_q;
  assign sel_o      = ctrl_q[2:0];
  assign alarm_en_o = ctrl_q[3];
endmodule

// File: rtl/tod_irq.sv
module tod_irq
  import tod_pkg::*;
#(
  parameter int HW = 7,
  parameter int MW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [2:0]    sel_i,
  input  logic          alarm_en_i,
  input  logic          hs_last_i,
  input  logic          mn_last_i,
  input  logic          hr_last_i,
  input  logic [HW-1:0] hs_nxt_i,
  input  logic [MW-1:0] mn_nxt_i,
  input  logic [RW-1:0] hr_nxt_i,
  input  logic [HW-1:0] a_hs_i,
  input  logic [MW-1:0] a_mn_i,
  input  logic [RW-1:0] a_hr_i,
  output logic          irq_interval_o,
  output logic          irq_alarm_o
);
  logic iv_d, al_d, iv_q, al_q;
  logic wrap_min, wrap_hr, wrap_day;

  always_comb begin
    wrap_min = hs_last_i;
    wrap_hr  = wrap_min & mn_last_i;
    wrap_day = wrap_hr & hr_last_i;
    case (iv_sel_e'(sel_i))
      IV_HALF: iv_d = adv_i;
      IV_SEC:  iv_d = adv_i & ~hs_nxt_i[0];
      IV_MIN:  iv_d = adv_i & wrap_min;
      IV_HOUR: iv_d = adv_i & wrap_hr;
      IV_DAY:  iv_d = adv_i & wrap_day;
      default: iv_d = 1'b0;
    endcase
    al_d = adv_i & alarm_en_i & (hs_nxt_i == a_hs_i) &
           (mn_nxt_i == a_mn_i) & (hr_nxt_i == a_hr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= 1'b0;
      al_q <= 1'b0;
    end else begin
      iv_q <= iv_d;
      al_q <= al_d;
    end
  end

  assign irq_interval_o = iv_q;
  assign irq_alarm_o    = al_q;
endmodule

// File: rtl/tod_alarm_counter.sv
module tod_alarm_counter
  import tod_pkg::*;
#(
  parameter int DW = 8,
  parameter int HS_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HR_PER_DAY = 24,
  parameter int PRE_DIV = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [2:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_interval_o,
  output logic          irq_alarm_o
);
  localparam int HW = $clog2(HS_PER_MIN);
  localparam int MW = $clog2(MIN_PER_HOUR);
  localparam int RW = $clog2(HR_PER_DAY);

  logic          ld_hs, ld_mn, ld_hr, wr_time_w, adv_w;
  logic [HW-1:0] hs_cnt, hs_nxt, a_hs;
  logic [MW-1:0] mn_cnt, mn_nxt, a_mn;
  logic [RW-1:0] hr_cnt, hr_nxt, a_hr;
  logic          hs_last, mn_last, hr_last;
  logic [2:0]    sel;
  logic          alarm_en;

  always_comb begin
    ld_hs     = wr_en_i && (wr_addr_i == ADR_HS);
    ld_mn     = wr_en_i && (wr_addr_i == ADR_MN);
    ld_hr     = wr_en_i && (wr_addr_i == ADR_HR);
    wr_time_w = ld_hs | ld_mn | ld_hr;
  end

  tod_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(wr_time_w), .adv_o(adv_w)
  );

  tod_digit #(.MOD(HS_PER_MIN), .W(HW), .DW(DW)) u_hs (
    .clk(clk), .rst_n(rst_n), .inc_i(adv_w), .ld_i(ld_hs), .ld_val_i(wr_data_i),
    .cnt_o(hs_cnt), .nxt_o(hs_nxt), .last_o(hs_last)
  );

  tod_digit #(.MOD(MIN_PER_HOUR), .W(MW), .DW(DW)) u_mn (
    .clk(clk), .rst_n(rst_n), .inc_i(adv_w & hs_last), .ld_i(ld_mn), .ld_val_i(wr_data_i),
    .cnt_o(mn_cnt), .nxt_o(mn_nxt), .last_o(mn_last)
  );

  tod_digit #(.MOD(HR_PER_DAY), .W(RW), .DW(DW)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc_i(adv_w & hs_last & mn_last), .ld_i(ld_hr),
    .ld_val_i(wr_data_i), .cnt_o(hr_cnt), .nxt_o(hr_nxt), .last_o(hr_last)
  );

  tod_regs #(
    .DW(DW), .HS_PER_MIN(HS_PER_MIN), .MIN_PER_HOUR(MIN_PER_HOUR), .HR_PER_DAY(HR_PER_DAY),
    .HW(HW), .MW(MW), .RW(RW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .hs_i(hs_cnt), .mn_i(mn_cnt), .hr_i(hr_cnt),
    .a_hs_o(a_hs), .a_mn_o(a_mn), .a_hr_o(a_hr), .sel_o(sel), .alarm_en_o(alarm_en),
    .rd_data_o(rd_data_o)
  );

  tod_irq #(.HW(HW), .MW(MW), .RW(RW)) u_irq (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_w), .sel_i(sel), .alarm_en_i(alarm_en),
    .hs_last_i(hs_last), .mn_last_i(mn_last), .hr_last_i(hr_last),
    .hs_nxt_i(hs_nxt), .mn_nxt_i(mn_nxt), .hr_nxt_i(hr_nxt),
    .a_hs_i(a_hs), .a_mn_i(a_mn), .a_hr_i(a_hr),
    .irq_interval_o(irq_interval_o), .irq_alarm_o(irq_alarm_o)
  );
endmodule

// File: rtl/tod_alarm_checker.sv
module tod_alarm_checker #(
  parameter int HS_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HR_PER_DAY = 24
) (
  input logic clk,
  input logic rst_n,
  input logic adv_i,
  input logic wr_time_i,
  input logic [$clog2(HS_PER_MIN)-1:0] hs_i,
  input logic [$clog2(MIN_PER_HOUR)-1:0] mn_i,
  input logic [$clog2(HR_PER_DAY)-1:0] hr_i,
  input logic irq_interval_i,
  input logic irq_alarm_i
);
  localparam int HW = $clog2(HS_PER_MIN);
  localparam int MW = $clog2(MIN_PER_HOUR);
  localparam int RW = $clog2(HR_PER_DAY);

  AST_HS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, hs_i} < (HW+1)'(HS_PER_MIN)); // R1

  AST_HS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (hs_i == (($past(hs_i) == HW'(HS_PER_MIN - 1)) ? HW'(0) : $past(hs_i) + 1'b1))); // R1

  AST_MN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, mn_i} < (MW+1)'(MIN_PER_HOUR)); // R2

  AST_HR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, hr_i} < (RW+1)'(HR_PER_DAY)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_time_i) |=> ($stable(hs_i) && $stable(mn_i) && $stable(hr_i))); // R2

  AST_WRITE_NO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time_i |=> !irq_interval_i); // R6

  AST_INTERVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_interval_i |-> $past(adv_i)); // R5

  AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm_i |=> !irq_alarm_i); // R8
endmodule

bind tod_alarm_counter tod_alarm_checker #(
  .HS_PER_MIN(HS_PER_MIN), .MIN_PER_HOUR(MIN_PER_HOUR), .HR_PER_DAY(HR_PER_DAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_i(adv_w), .wr_time_i(wr_time_w),
  .hs_i(hs_cnt), .mn_i(mn_cnt), .hr_i(hr_cnt),
  .irq_interval_i(irq_interval_o), .irq_alarm_i(irq_alarm_o)
);

// File: tb/test_tod_alarm_counter.sv
module test_tod_alarm_counter;
  localparam int DW  = 8;
  localparam int HPM = 4;
  localparam int MPH = 3;
  localparam int HPD = 2;
  localparam int DIV = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_i, wr_en_i, rd_en_i;
  logic [2:0]    wr_addr_i, rd_addr_i;
  logic [DW-1:0] wr_data_i;
  logic [DW-1:0] rd_data_o;
  logic          irq_interval_o, irq_alarm_o;

  int n_vec = 0;
  int n_bad = 0;
  int m_hs, m_mn, m_hr, m_sel;

  always #10 clk = ~clk;

  tod_alarm_counter #(
    .DW(DW), .HS_PER_MIN(HPM), .MIN_PER_HOUR(MPH), .HR_PER_DAY(HPD), .PRE_DIV(DIV)
  ) i_tod_alarm_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_interval_o(irq_interval_o), .irq_alarm_o(irq_alarm_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic latch, output logic [7:0] v);
    rd_addr_i = a; rd_en_i = latch;
    #1 v = rd_data_o;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic tick(output logic ii, output logic ia);
    tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
    ii = irq_interval_o; ia = irq_alarm_o;
  endtask

  // model step for one advance; returns expected interval pulse
  task automatic model_adv(output logic ev);
    int ohs, omn, ohr;
    ohs = m_hs; omn = m_mn; ohr = m_hr;
    m_hs = (ohs == HPM-1) ? 0 : ohs + 1;
    if (ohs == HPM-1) begin
      m_mn = (omn == MPH-1) ? 0 : omn + 1;
      if (omn == MPH-1) m_hr = (ohr == HPD-1) ? 0 : ohr + 1;
    end
    case (m_sel)
      1: ev = 1'b1;
      2: ev = (m_hs % 2) == 0;
      3: ev = (ohs == HPM-1);
      4: ev = (ohs == HPM-1) && (omn == MPH-1);
      5: ev = (ohs == HPM-1) && (omn == MPH-1) && (ohr == HPD-1);
      default: ev = 1'b0;
    endcase
  endtask

  task automatic adv(output logic ii, output logic ia);
    logic d0, d1;
    tick(d0, d1);
    tick(ii, ia);
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(3'd0, 8'(s)); wr(3'd1, 8'(m)); wr(3'd2, 8'(h));
    m_hs = s; m_mn = m; m_hr = h;
  endtask

  task automatic check_time(input string tag);
    logic [7:0] v;
    rd(3'd0, 1'b1, v); chk("R1", {tag, " half-seconds"}, v, m_hs);
    rd(3'd1, 1'b0, v); chk("R2", {tag, " minutes"}, v, m_mn);
    rd(3'd2, 1'b0, v); chk("R2", {tag, " hours"}, v, m_hr);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R10", "interval irq after reset", irq_interval_o, 0);
    chk("R10", "alarm irq after reset", irq_alarm_o, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), 1'b0, v);
      chk("R10", $sformatf("reset read addr %0d", a), v, 0);
    end
  endtask

  task automatic t_count;
    logic ii, ia, ev;
    m_sel = 1; wr(3'd6, 8'd1);
    set_time(0, 0, 0);
    for (int i = 0; i < 30; i++) begin
      adv(ii, ia);
      model_adv(ev);
      chk("R5", "interval every advance", ii, ev);
      chk("R7", "alarm stays off when disabled", ia, 0);
      check_time("count");
    end
  endtask

  task automatic t_modes;
    logic ii, ia, ev;
    int sels[6] = '{0, 2, 3, 4, 5, 6};
    for (int k = 0; k < 6; k++) begin
      m_sel = sels[k]; wr(3'd6, 8'(sels[k]));
      set_time(0, 0, 0);
      for (int i = 0; i < 24; i++) begin
        adv(ii, ia);
        model_adv(ev);
        chk("R5", $sformatf("interval sel %0d step %0d", sels[k], i), ii, ev);
      end
      check_time("after day");
    end
  endtask

  task automatic t_prescale;
    logic ii, ia, ev;
    logic [7:0] v;
    m_sel = 1; wr(3'd6, 8'd1);
    set_time(0, 0, 1);
    tick(ii, ia);
    chk("R3", "no pulse on first tick", ii, 0);
    rd(3'd0, 1'b0, v); chk("R3", "hold after first tick", v, 1);
    tick(ii, ia); model_adv(ev);
    chk("R3", "pulse on second tick", ii, ev);
    rd(3'd0, 1'b0, v); chk("R3", "advance on second tick", v, m_hs);
    tick(ii, ia);
    wr(3'd0, 8'd3); m_hs = 3;
    tick(ii, ia);
    chk("R3", "no pulse after write restart", ii, 0);
    rd(3'd0, 1'b0, v); chk("R3", "hold after write restart", v, 3);
    tick(ii, ia); model_adv(ev);
    chk("R3", "pulse after full count", ii, ev);
    check_time("prescale");
  endtask

  task automatic t_write_block;
    logic ii, ia, ev;
    logic [7:0] v;
    m_sel = 1; wr(3'd6, 8'd1);
    set_time(0, 0, 0);
    tick(ii, ia);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'd2;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    m_hs = 2;
    chk("R6", "no interval with concurrent write", irq_interval_o, 0);
    rd(3'd0, 1'b0, v); chk("R6", "write wins over tick", v, 2);
    tick(ii, ia);
    chk("R3", "prescaler restarted by write", ii, 0);
    tick(ii, ia); model_adv(ev);
    chk("R6", "pulse resumes after write", ii, ev);
    rd(3'd0, 1'b0, v); chk("R1", "advance after write", v, 3);
  endtask

  task automatic t_range;
    logic [7:0] v;
    wr(3'd0, 8'd3); rd(3'd0, 1'b0, v); chk("R4", "in-range half-second", v, 3);
    wr(3'd0, 8'd4); rd(3'd0, 1'b0, v); chk("R4", "out-of-range half-second", v, 0);
    wr(3'd1, 8'd2); wr(3'd1, 8'd200); rd(3'd0, 1'b1, v); rd(3'd1, 1'b0, v);
    chk("R4", "out-of-range minute", v, 0);
    wr(3'd2, 8'd1); rd(3'd0, 1'b1, v); rd(3'd2, 1'b0, v);
    chk("R4", "in-range hour", v, 1);
    wr(3'd2, 8'd2); rd(3'd0, 1'b1, v); rd(3'd2, 1'b0, v);
    chk("R4", "out-of-range hour", v, 0);
    wr(3'd3, 8'd9); rd(3'd3, 1'b0, v); chk("R4", "out-of-range alarm field", v, 0);
  endtask

  task automatic t_alarm;
    logic ii, ia, ev;
    logic [7:0] v;
    m_sel = 0;
    wr(3'd6, 8'h08);
    wr(3'd3, 8'd1); wr(3'd4, 8'd2); wr(3'd5, 8'd1);
    rd(3'd3, 1'b0, v); chk("R10", "alarm half-second readback", v, 1);
    rd(3'd4, 1'b0, v); chk("R10", "alarm minute readback", v, 2);
    rd(3'd5, 1'b0, v); chk("R10", "alarm hour readback", v, 1);
    rd(3'd6, 1'b0, v); chk("R10", "control readback", v, 8);
    set_time(1, 2, 0);
    adv(ii, ia); model_adv(ev);
    chk("R7", "alarm on match", ia, 1);
    chk("R5", "interval off with sel 0", ii, 0);
    for (int i = 0; i < 24; i++) begin
      adv(ii, ia); model_adv(ev);
      chk("R8", $sformatf("alarm step %0d", i), ia,
          (m_hs == 1 && m_mn == 2 && m_hr == 1) ? 1 : 0);
    end
    set_time(1, 2, 0);
    wr(3'd0, 8'd1);
    chk("R7", "no alarm on direct write", irq_alarm_o, 0);
    wr(3'd6, 8'h00);
    set_time(1, 2, 0);
    adv(ii, ia);
    chk("R7", "no alarm when disabled", ia, 0);
  endtask

  task automatic t_snap;
    logic ii, ia, ev;
    logic [7:0] v;
    m_sel = 0; wr(3'd6, 8'd0);
    set_time(0, 1, 3);
    rd(3'd0, 1'b1, v); chk("R9", "live half-second", v, 3);
    adv(ii, ia); model_adv(ev);
    rd(3'd1, 1'b1, v); chk("R9", "minute from latch", v, 1);
    rd(3'd2, 1'b0, v); chk("R9", "hour from latch", v, 0);
    rd(3'd0, 1'b1, v); chk("R9", "half-second after carry", v, 0);
    rd(3'd1, 1'b0, v); chk("R9", "minute after relatch", v, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    wr_addr_i = '0; rd_addr_i = '0; wr_data_i = '0;
    m_hs = 0; m_mn = 0; m_hr = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_modes;
    t_prescale;
    t_write_block;
    t_range;
    t_alarm;
    t_snap;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule